// File: doc/BRIEF.md
# Pointer-Addressed Packet Memory Port

This block lets a host move 32-bit words into and out of a packet memory by way of two registers: a pointer register and a data register. The pointer register holds an 11-bit byte address, a direction bit that picks read or write mode, and a live read-only flag that shows whether the write FIFO still holds words on their way to memory. Each data-register access moves one word at the address in the pointer and then advances the pointer by four bytes. Writes pass through a four-entry FIFO that drains to memory at one word per clock. Reads are served from a one-word prefetch register that is loaded when the pointer is written in read mode, and again after every data read.

A direct-select input sends every access to the data register, whatever offset the host drives. It also treats every such access as a full 32-bit word, so back-to-back burst transfers need no address decode. When the host must wait, the port holds ready low. This happens for a data read whose prefetched word has not yet arrived, and for a data write while the FIFO is full. The packet memory is an internal RAM.

Top module: `ptr_data_port`

## Requirements
- R1: After reset the pointer register reads 0x0000 (write mode, address 0, FIFO empty) and ready is high.
- R2: Pointer register image in bits 15:0: bits 10:0 are the byte address, bit 15 is the direction (1 = read mode, 0 = write mode), bit 14 is the read-only FIFO-not-empty flag, and bits 13:11 read 0. Writes to bits 14:11 are ignored.
- R3: Bit 14 of the pointer reads 1 whenever the write FIFO holds at least one word, and 0 once it has drained.
- R4: Every completed data access moves the word at memory index pointer[10:2] and then adds 4 to the pointer, modulo 2^11. Pointer bits 1:0 are kept but play no part in addressing.
- R5: A data write through the normal decode (offset 1) updates only the byte lanes whose byte enables are set. Lane n is wdata bits 8n+7:8n.
- R6: With direct select high, an access at any offset goes to the data register and writes all four bytes, whatever the byte enables are. An access at offset 0 then leaves the pointer value alone, apart from its increment.
- R7: The write FIFO holds 4 words and drains one word per clock. Ready is low for a data write only while the FIFO is full, so a continuous write burst completes one word per clock with no stall.
- R8: Writing the pointer with bit 15 set starts a prefetch. A data read holds ready low until the word arrives, returns the word at the pointer, and then prefetches the next word.
- R9: A prefetch waits until the write FIFO is empty, so reads return every word written earlier.
- R10: A data write in read mode, or a data read in write mode, completes at once and changes neither memory nor pointer. Such a read returns 0.
- R11: Offsets 2 and 3 without direct select read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host access request, held until ready |
| we | input | 1 | 1 = write access, 0 = read access |
| dsel | input | 1 | Direct data select: force data-register, full-word access |
| addr | input | 2 | Register offset: 0 pointer, 1 data |
| be | input | 4 | Byte enables for data writes through the normal decode |
| wdata | input | 32 | Write data |
| ready | output | 1 | Access completes on the clock edge where req and ready are both high |
| rdata | output | 32 | Read data, valid while req and ready are high |

## Verification
All 512 memory words are written with a direct-select burst and then read back with a normal read sweep. Each word carries a distinct value that depends on its index, so any addressing fault, missed increment or wrap error shows up as a value mismatch. All sixteen byte-enable patterns are applied on normal writes, each with different pointer low bits, over known old contents. This separates correct lane merging from forced full-word writes and shows that the low address bits are ignored. Further short sequences cover the following:
- a write followed at once by a read, which tells a prefetch that waits for the FIFO from one that reads stale memory;
- direction-mismatched accesses;
- unused offsets;
- direct-select accesses at the pointer offset, which tell a true bypass from a pointer overwrite.

// File: rtl/ptrport_pkg.sv
package ptrport_pkg;
  localparam int PTR_W   = 11;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;
  localparam int WIDX_W  = PTR_W - 2;
  localparam int REG_W   = 16;
  localparam int DIR_BIT = 15;
  localparam int NE_BIT  = 14;
  localparam int OFS_W   = 2;
  localparam logic [OFS_W-1:0] OFS_PTR  = 2'd0;
  localparam logic [OFS_W-1:0] OFS_DATA = 2'd1;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_PTR_RD, ACC_PTR_WR, ACC_DAT_RD, ACC_DAT_WR, ACC_OTHER
  } acc_e;

  typedef struct packed {
    logic [WIDX_W-1:0] widx;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } wentry_t;

  function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p);
    return p + PTR_W'(BE_W);
  endfunction

  function automatic logic [WIDX_W-1:0] word_of(input logic [PTR_W-1:0] p);
    return p[PTR_W-1:2];
  endfunction

  function automatic logic [REG_W-1:0] ptr_image(input logic dir, input logic ne,
                                                 input logic [PTR_W-1:0] p);
    logic [REG_W-1:0] img;
    img = '0;
    img[PTR_W-1:0] = p;
    img[NE_BIT]    = ne;
    img[DIR_BIT]   = dir;
    return img;
  endfunction
endpackage

// File: rtl/host_decode.sv
module host_decode
  import ptrport_pkg::*;
(
  input  logic             req,
  input  logic             we,
  input  logic             dsel,
  input  logic [OFS_W-1:0] addr,
  input  logic [BE_W-1:0]  be,
  output acc_e             kind,
  output logic [BE_W-1:0]  eff_be
);
  always_comb begin
    if (!req) kind = ACC_NONE;
    else if (dsel) kind = we ? ACC_DAT_WR : ACC_DAT_RD;
    else if (addr == OFS_PTR) kind = we ? ACC_PTR_WR : ACC_PTR_RD;
    else if (addr == OFS_DATA) kind = we ? ACC_DAT_WR : ACC_DAT_RD;
    else kind = ACC_OTHER;
  end

  assign eff_be = dsel ? {BE_W{1'b1}} : be;
endmodule

// File: rtl/wr_fifo.sv
module wr_fifo
  import ptrport_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  wentry_t din,
  input  logic    pop,
  output wentry_t head,
  output logic    full,
  output logic    empty
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wentry_t          slots [DEPTH];
  logic [AW-1:0]    wr_i, rd_i;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slots[rd_i];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] i);
    return (i == AW'(DEPTH - 1)) ? '0 : i + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_i  <= '0;
      rd_i  <= '0;
      count <= '0;
    end else begin
      if (do_push) begin
        slots[wr_i] <= din;
        wr_i        <= bump(wr_i);
      end
      if (do_pop) rd_i <= bump(rd_i);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // R7
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/pkt_ram.sv
module pkt_ram
  import ptrport_pkg::*;
#(
  parameter int WORDS = 1 << WIDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WIDX_W-1:0] waddr,
  input  logic [BE_W-1:0]   wbe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [WIDX_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
    logic [7:0] bank [WORDS];
    always_ff @(posedge clk) begin
      if (we && wbe[lane]) bank[waddr] <= wdata[lane*8 +: 8];
      if (re) q[lane*8 +: 8] <= bank[raddr];
    end
  end
endmodule

// File: rtl/ptr_data_port.sv
module ptr_data_port
  import ptrport_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              dsel,
  input  logic [OFS_W-1:0]  addr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata
);
  acc_e              kind;
  logic [BE_W-1:0]   push_be;
  logic [PTR_W-1:0]  ptr_q;
  logic              rd_mode;
  logic              pf_valid, pf_pend, pf_load;
  logic [DATA_W-1:0] pf_data;
  logic [DATA_W-1:0] ram_q;
  logic              fifo_full, fifo_empty;
  wentry_t           fifo_head, fifo_din;

  // named internal events
  logic fire, ptr_wr_fire, dwr_fire, drd_fire, fetch_go, mismatch_fire;

  host_decode u_dec (
    .req(req), .we(we), .dsel(dsel), .addr(addr), .be(be),
    .kind(kind), .eff_be(push_be)
  );

  always_comb begin
    case (kind)
      ACC_DAT_WR: ready = rd_mode ? 1'b1 : !fifo_full;
      ACC_DAT_RD: ready = rd_mode ? pf_valid : 1'b1;
      default:    ready = 1'b1;
    endcase
  end

  assign fire          = req && ready;
  assign ptr_wr_fire   = fire && (kind == ACC_PTR_WR);
  assign dwr_fire      = fire && (kind == ACC_DAT_WR) && !rd_mode;
  assign drd_fire      = fire && (kind == ACC_DAT_RD) && rd_mode;
  assign mismatch_fire = fire && (((kind == ACC_DAT_WR) && rd_mode) ||
                                  ((kind == ACC_DAT_RD) && !rd_mode));
  assign fetch_go      = pf_pend && fifo_empty && !ptr_wr_fire;

  assign fifo_din = '{widx: word_of(ptr_q), be: push_be, data: wdata};

  wr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(dwr_fire), .din(fifo_din),
    .pop(!fifo_empty), .head(fifo_head),
    .full(fifo_full), .empty(fifo_empty)
  );

  pkt_ram u_ram (
    .clk(clk),
    .we(!fifo_empty), .waddr(fifo_head.widx), .wbe(fifo_head.be), .wdata(fifo_head.data),
    .re(fetch_go), .raddr(word_of(ptr_q)), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rd_mode <= 1'b0;
    end else if (ptr_wr_fire) begin
      ptr_q   <= wdata[PTR_W-1:0];
      rd_mode <= wdata[DIR_BIT];
    end else if (dwr_fire || drd_fire) begin
      ptr_q   <= ptr_advance(ptr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_pend  <= 1'b0;
      pf_load  <= 1'b0;
      pf_data  <= '0;
    end else if (ptr_wr_fire) begin
      pf_valid <= 1'b0;
      pf_pend  <= wdata[DIR_BIT];
      pf_load  <= 1'b0;
    end else begin
      pf_load <= fetch_go;
      if (fetch_go) pf_pend <= 1'b0;
      if (drd_fire) begin
        pf_valid <= 1'b0;
        pf_pend  <= 1'b1;
      end else if (pf_load) begin
        pf_valid <= 1'b1;
        pf_data  <= ram_q;
      end
    end
  end

  always_comb begin
    case (kind)
      ACC_PTR_RD: rdata = DATA_W'(ptr_image(rd_mode, !fifo_empty, ptr_q));
      ACC_DAT_RD: rdata = rd_mode ? pf_data : '0;
      default:    rdata = '0;
    endcase
  end

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_fire || drd_fire) |=> (PTR_W'(ptr_q - $past(ptr_q)) == PTR_W'(4)));

  // R6
  dsel_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_fire && dsel) |-> (push_be == {BE_W{1'b1}}));

  // R8
  pf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_fire |=> !pf_valid);

  // R9
  pf_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> fifo_empty);

  // R10
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_fire |=> (ptr_q == $past(ptr_q)));
endmodule

// File: tb/tb_ptr_data_port.sv
module tb_ptr_data_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, dsel = 1'b0;
  logic [1:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;
  logic [31:0] mem_m [512];

  ptr_data_port dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .dsel(dsel), .addr(addr),
    .be(be), .wdata(wdata), .ready(ready), .rdata(rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0001_0003) ^ 32'h5A00_00A5 ^ (32'(i) << 20);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] m);
    logic [31:0] r;
    r = old;
    for (int k = 0; k < 4; k++) if (m[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FIFO check FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      summary();
    end
  end

  task automatic bus(input logic w, input logic ds, input logic [1:0] a, input logic [3:0] b,
                     input logic [31:0] wd, output logic [31:0] rd, output int waits);
    req = 1'b1; we = w; dsel = ds; addr = a; be = b; wdata = wd; waits = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1; waits++;
    end
    rd = rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] rd;
  int w, stalls;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0 && w == 0, "R1 reset pointer/ready", rd, 32'h0);

    // R2 layout and read-only bits
    bus(1, 0, 2'd0, 4'hF, 32'h0000_7FFF, rd, w);
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0000_07FF, "R2 bits 14:11 ignored", rd, 32'h07FF);
    bus(1, 0, 2'd0, 4'hF, 32'h0000_8123, rd, w);
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0000_8123, "R2 direction bit", rd, 32'h8123);

    // R6 R7 direct-select burst over all words, be forced full
    bus(1, 0, 2'd0, 4'hF, 32'h0, rd, w);
    stalls = 0;
    for (int i = 0; i < 512; i++) begin
      bus(1, 1, 2'd0, 4'h0, pat(i), rd, w);
      stalls += w;
      mem_m[i] = pat(i);
    end
    chk(stalls == 0, "R7 burst stalls", 32'(stalls), 32'h0);
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0000_4000, "R3 R4 not-empty and wrap after burst", rd, 32'h4000);
    idle(2);
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0, "R3 flag clears after drain", rd, 32'h0);

    // R8 R4 read sweep through normal decode
    bus(1, 0, 2'd0, 4'hF, 32'h0000_8000, rd, w);
    for (int i = 0; i < 512; i++) begin
      bus(0, 0, 2'd1, 4'h0, 32'h0, rd, w);
      if (i == 0) chk(w > 0, "R8 first read waits for prefetch", 32'(w), 32'h1);
      chk(rd == mem_m[i], "R8 read sweep data", rd, mem_m[i]);
    end
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0000_8000, "R4 read pointer wrap", rd, 32'h8000);

    // R5 R4 byte-enable sweep with pointer low bits set
    for (int b = 0; b < 16; b++) begin
      bus(1, 0, 2'd0, 4'hF, 32'(((32 + b) << 2) | (b & 3)), rd, w);
      bus(1, 0, 2'd1, 4'(b), 32'hF0E1_D2C3 ^ 32'(b), rd, w);
      mem_m[32 + b] = merge(mem_m[32 + b], 32'hF0E1_D2C3 ^ 32'(b), 4'(b));
    end
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0000_40C3, "R4 low bits kept across increment", rd, 32'h40C3);
    bus(1, 0, 2'd0, 4'hF, 32'h0000_8080, rd, w);
    for (int b = 0; b < 16; b++) begin
      bus(0, 0, 2'd1, 4'h0, 32'h0, rd, w);
      chk(rd == mem_m[32 + b], "R5 byte lane merge", rd, mem_m[32 + b]);
    end

    // R10 data write in read mode ignored (pointer now 0x80C0)
    bus(1, 0, 2'd1, 4'hF, 32'h1234_5678, rd, w);
    chk(w == 0, "R10 mismatched write completes at once", 32'(w), 32'h0);
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0000_80C0, "R10 pointer unchanged", rd, 32'h80C0);
    bus(0, 0, 2'd1, 4'h0, 32'h0, rd, w);
    chk(rd == mem_m[48], "R10 memory unchanged", rd, mem_m[48]);
    // R10 data read in write mode
    bus(1, 0, 2'd0, 4'hF, 32'h0000_0300, rd, w);
    bus(0, 0, 2'd1, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0 && w == 0, "R10 write-mode read returns 0", rd, 32'h0);
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0000_0300, "R10 pointer unchanged by read", rd, 32'h0300);

    // R11 unused offsets
    bus(1, 0, 2'd0, 4'hF, 32'h0000_0100, rd, w);
    bus(1, 0, 2'd2, 4'hF, 32'h0000_8055, rd, w);
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0000_0100, "R11 offset 2 write ignored", rd, 32'h0100);
    bus(0, 0, 2'd3, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0, "R11 offset 3 reads 0", rd, 32'h0);

    // R6 direct select at pointer offset goes to data, full word
    bus(1, 1, 2'd0, 4'h0, 32'hDEAD_8000, rd, w);
    mem_m[64] = 32'hDEAD_8000;
    bus(0, 0, 2'd0, 4'h0, 32'h0, rd, w);
    chk(rd == 32'h0000_4104, "R6 pointer not overwritten by bypass", rd, 32'h4104);
    idle(2);
    bus(1, 0, 2'd0, 4'hF, 32'h0000_8100, rd, w);
    for (int i = 0; i < 3; i++) begin
      bus(0, 1, 2'd0, 4'h0, 32'h0, rd, w);
      chk(rd == mem_m[64 + i], "R6 direct-select read burst", rd, mem_m[64 + i]);
    end

    // R9 write then read at once
    bus(1, 0, 2'd0, 4'hF, 32'h0000_0200, rd, w);
    for (int i = 0; i < 3; i++) begin
      bus(1, 0, 2'd1, 4'hF, 32'hC0DE_0000 + 32'(i), rd, w);
      mem_m[128 + i] = 32'hC0DE_0000 + 32'(i);
    end
    bus(1, 0, 2'd0, 4'hF, 32'h0000_8200, rd, w);
    for (int i = 0; i < 3; i++) begin
      bus(0, 0, 2'd1, 4'h0, 32'h0, rd, w);
      chk(rd == mem_m[128 + i], "R9 read sees FIFO data", rd, mem_m[128 + i]);
    end

    idle(2);
    summary();
  end
endmodule